// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Write Arbitration

This block is a synchronous RAM with two symmetric ports, A and B, clocked by one shared clock. Each port carries its own address, write data, write enable, read enable and per-lane byte enables. In any cycle each port may read, write, do both, or stay idle, at any location. A read returns its data on the output one clock edge after the request is sampled. The output then holds that value until the next read on the same port.

The storage array itself cannot settle two writes to one word in the same cycle, so the block carries its own arbitration. The check is done lane by lane. Where both ports enable the same lane of the same address, port A's bytes are stored and port B's bytes are discarded. Lanes that only one port enables are written by that port. A flag output pulses for the cycle after any such contention. This lets surrounding logic retry or log the lost write.

Read-during-write has two rules:

- On the port that writes, a parameter chooses whether the read returns the freshly written lanes or the previous contents.
- A port that reads a word the other port is writing in the same cycle always receives the previous contents.

Top module: `tdp_ram_arb`

## Requirements
- R1: In every cycle each port independently performs a read, a write, both or neither at any address. Read data for a request sampled at one rising edge appears on that port's output after that same edge.
- R2: DATA_W is 8, 9, 16 or 18. The lane width is 9 when DATA_W is 9 or 18, and 8 otherwise. Lane l occupies data bits [l*LANE_W +: LANE_W], and byte-enable bit l controls lane l. Any other width, such as 32 or 36, stops elaboration.
- R3: When a port reads and writes the same cycle, its read returns its own committed write lanes if NEW_DATA=1. All other lanes, and every lane when NEW_DATA=0, return the contents stored before the edge.
- R4: A port reading an address that the other port writes in the same cycle receives the contents stored before that write.
- R5: A write changes only the lanes whose byte-enable bit is 1. All other lanes of the word keep their previous value.
- R6: While a port's read enable is 0, its read-data output keeps its last value.
- R7: While reset (active-low, asynchronous) is asserted, both read-data outputs and the collision flag are 0.
- R8: When both ports write the same address with overlapping lane enables, port A's data is stored in the shared lanes. The collision flag is 1 in the cycle after that edge and 0 after any edge without a collision.
- R9: Two reads of one address in the same cycle return the same stored word and raise no collision flag.
- R10: In a same-address dual write, a lane enabled by only one port takes that port's data. When the two enable masks do not overlap, no collision is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of outputs and flag |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_we | input | 1 | Port A write enable |
| a_re | input | 1 | Port A read enable |
| a_be | input | LANES | Port A lane enables, bit l for lane l |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_we | input | 1 | Port B write enable |
| b_re | input | 1 | Port B read enable |
| b_be | input | LANES | Port B lane enables, bit l for lane l |
| a_rdata | output | DATA_W | Port A read data |
| b_rdata | output | DATA_W | Port B read data |
| collide | output | 1 | One-cycle flag after a same-address, same-lane dual write |

## Verification
Directed cases are applied first, each separating one rule from its neighbours:

- A full-width write read back from the other port checks lane placement.
- A partial-lane write checks masking.
- A write and read on one port checks new-data forwarding, as opposed to the cross-port old-data return from a read on the other port.
- Overlapping, partly overlapping and disjoint dual writes to one word tell port-A priority apart from per-lane merging and from the absence of a flag.
- Idle cycles after reads expose any output that fails to hold.

Random traffic then confines both addresses to eight words so that same-address reads, writes and mixed lane masks arise often. Every cycle is compared against a lane-level reference model.

// File: rtl/tdp_ram_arb.sv
module tdp_ram_arb #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter bit NEW_DATA = 1'b1,
  localparam int LANE_W  = (DATA_W == 9 || DATA_W == 18) ? 9 : 8,
  localparam int LANES   = (DATA_W + LANE_W - 1) / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              a_we,
  input  logic              a_re,
  input  logic [LANES-1:0]  a_be,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic              b_we,
  input  logic              b_re,
  input  logic [LANES-1:0]  b_be,
  output logic [DATA_W-1:0] a_rdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              collide
);

  localparam int DEPTH = 1 << ADDR_W;

  // R2: only the widths a lane-organised word of at most two lanes supports
  if (!(DATA_W == 8 || DATA_W == 9 || DATA_W == 16 || DATA_W == 18)) begin : g_bad_width
    $error("tdp_ram_arb: DATA_W must be 8, 9, 16 or 18");
  end

  logic [DATA_W-1:0] mem [DEPTH];

  logic             same_addr;
  logic [LANES-1:0] a_wl, b_wl, both_l;

  assign same_addr = (a_addr == b_addr);
  assign a_wl      = {LANES{a_we}} & a_be;
  assign both_l    = a_wl & {LANES{b_we}} & b_be & {LANES{same_addr}};
  assign b_wl      = {LANES{b_we}} & b_be & ~both_l;

  function automatic logic [DATA_W-1:0] fwd(input logic [DATA_W-1:0] old,
                                            input logic [DATA_W-1:0] wd,
                                            input logic [LANES-1:0]  wl);
    logic [DATA_W-1:0] r;
    r = old;
    for (int l = 0; l < LANES; l++)
      if (NEW_DATA && wl[l]) r[l*LANE_W +: LANE_W] = wd[l*LANE_W +: LANE_W];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (b_wl[l]) mem[b_addr][l*LANE_W +: LANE_W] <= b_wdata[l*LANE_W +: LANE_W];
      if (a_wl[l]) mem[a_addr][l*LANE_W +: LANE_W] <= a_wdata[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rdata <= '0;
      b_rdata <= '0;
      collide <= 1'b0;
    end else begin
      if (a_re) a_rdata <= fwd(mem[a_addr], a_wdata, a_wl);
      if (b_re) b_rdata <= fwd(mem[b_addr], b_wdata, b_wl);
      collide <= |both_l;
    end
  end

  p_hold_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !a_re |=> $stable(a_rdata));
  p_hold_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !b_re |=> $stable(b_rdata));

  p_cross_old_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (b_re && !b_we && a_we && same_addr) |=> (b_rdata == $past(mem[b_addr])));

  p_same_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_re && a_we && (&a_be)) |=>
      (a_rdata == (NEW_DATA ? $past(a_wdata) : $past(mem[a_addr]))));

  p_a_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_we && b_we && same_addr && (&a_be) && (&b_be)) |=>
      (collide && mem[$past(a_addr)] == $past(a_wdata)));

  p_two_reads_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (a_re && b_re && !a_we && !b_we && same_addr) |=> (a_rdata == b_rdata && !collide));

endmodule

// File: tb/tb_tdp_ram_arb.sv
`timescale 1ns/1ps
module tb_tdp_ram_arb;
  localparam int AW = 6, DW = 16, LW = 8, NL = 2;
  localparam bit NEWD = 1'b1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic          a_we, a_re, b_we, b_re, collide;
  logic [NL-1:0] a_be, b_be;

  tdp_ram_arb #(.ADDR_W(AW), .DATA_W(DW), .NEW_DATA(NEWD)) dut (
    .clk(clk), .rst_n(rst_n),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_we(a_we), .a_re(a_re), .a_be(a_be),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_we(b_we), .b_re(b_re), .b_be(b_be),
    .a_rdata(a_rdata), .b_rdata(b_rdata), .collide(collide));

  logic [DW-1:0] model [1<<AW];
  logic [DW-1:0] exp_a, exp_b;
  logic          exp_c;
  int vecs = 0, errs = 0;
  bit done = 0;

  task automatic chk(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rd_exp(input logic [DW-1:0] old, input logic [DW-1:0] wd,
                                           input logic [NL-1:0] wl);
    logic [DW-1:0] r = old;
    for (int l = 0; l < NL; l++)
      if (NEWD && wl[l]) r[l*LW +: LW] = wd[l*LW +: LW];
    return r;
  endfunction

  task automatic idle();
    a_we = 0; a_re = 0; b_we = 0; b_re = 0; a_be = '1; b_be = '1;
  endtask

  // apply current inputs for one edge, predict, compare just after the edge
  task automatic step(input string ta = "", input string tb = "", input string tc = "");
    logic same;
    logic [NL-1:0] wa, wb, both;
    string sa, sb, sc;
    same = (a_addr == b_addr);
    wa   = {NL{a_we}} & a_be;
    both = wa & {NL{b_we}} & b_be & {NL{same}};
    wb   = {NL{b_we}} & b_be & ~both;
    if (a_re) exp_a = rd_exp(model[a_addr], a_wdata, wa);
    if (b_re) exp_b = rd_exp(model[b_addr], b_wdata, wb);
    exp_c = |both;
    sa = !a_re ? "R6" : (b_we && same && |b_be && !a_we) ? "R4" : a_we ? "R3" : "R1";
    sb = !b_re ? "R6" : (a_we && same && |a_be && !b_we) ? "R4" : b_we ? "R3" : "R1";
    sc = exp_c ? ((both != wa || (b_be & ~a_be) != 0) ? "R10" : "R8")
               : (a_re && b_re && same && !a_we && !b_we) ? "R9" : "R1";
    if (ta != "") sa = ta;
    if (tb != "") sb = tb;
    if (tc != "") sc = tc;
    for (int l = 0; l < NL; l++) begin
      if (wb[l]) model[b_addr][l*LW +: LW] = b_wdata[l*LW +: LW];
      if (wa[l]) model[a_addr][l*LW +: LW] = a_wdata[l*LW +: LW];
    end
    @(posedge clk); #1;
    chk(sa, "a_rdata", a_rdata, exp_a);
    chk(sb, "b_rdata", b_rdata, exp_b);
    chk(sc, "collide", {{(DW-1){1'b0}}, collide}, {{(DW-1){1'b0}}, exp_c});
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    idle(); a_addr = 0; b_addr = 0; a_wdata = 0; b_wdata = 0;
    rst_n = 0; exp_a = 0; exp_b = 0; exp_c = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R7", "a_rdata in reset", a_rdata, '0);
    chk("R7", "b_rdata in reset", b_rdata, '0);
    chk("R7", "collide in reset", {{(DW-1){1'b0}}, collide}, '0);
    rst_n = 1;

    for (int i = 0; i < 32; i++) begin
      a_we = 1; b_we = 1; a_addr = AW'(i); b_addr = AW'(i + 32);
      a_wdata = DW'($urandom); b_wdata = DW'($urandom);
      step();
    end
    idle();

    a_we = 1; a_addr = 1; a_wdata = 16'hA55A; step();
    idle(); b_re = 1; b_addr = 1; step("", "R2");
    idle(); a_we = 1; a_be = 2'b01; a_addr = 2; a_wdata = 16'h1234; step();
    idle(); a_re = 1; a_addr = 2; step("R5");
    idle(); a_we = 1; b_we = 1; a_addr = 3; b_addr = 3; a_wdata = 16'h1111; b_wdata = 16'h2222; step("", "", "R8");
    idle(); a_re = 1; a_addr = 3; step("R8", "", "R8");
    idle(); a_we = 1; b_we = 1; a_addr = 4; b_addr = 4; a_be = 2'b01; b_be = 2'b11;
    a_wdata = 16'h3344; b_wdata = 16'h5566; step("", "", "R10");
    idle(); b_re = 1; b_addr = 4; step("", "R10");
    idle(); a_we = 1; b_we = 1; a_addr = 4; b_addr = 4; a_be = 2'b01; b_be = 2'b10;
    a_wdata = 16'h7788; b_wdata = 16'h99AA; step("", "", "R10");
    idle(); a_re = 1; a_addr = 4; step("R10");
    idle(); a_we = 1; a_addr = 5; a_wdata = 16'hBEEF; b_re = 1; b_addr = 5; step("", "R4");
    idle(); a_we = 1; a_re = 1; a_addr = 6; a_wdata = 16'hCAFE; step("R3");
    idle(); a_re = 1; b_re = 1; a_addr = 7; b_addr = 7; step("R9", "R9", "R9");
    idle(); a_we = 1; b_we = 1; a_addr = 8; b_addr = 9; a_wdata = 16'h0F0F; b_wdata = 16'hF0F0; step("R6", "R6", "R1");
    idle(); step("R6", "R6");

    for (int n = 0; n < 4000; n++) begin
      a_addr = AW'($urandom % 8); b_addr = AW'($urandom % 8);
      a_we = 1'($urandom); b_we = 1'($urandom); a_re = 1'($urandom); b_re = 1'($urandom);
      a_be = NL'($urandom); b_be = NL'($urandom);
      a_wdata = DW'($urandom); b_wdata = DW'($urandom);
      step();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule